// File: doc/BRIEF.md
# JTAG Scan Chain Select Sequencer

This block is a JTAG master that attaches one internal scan chain of a processor debug port to the TDI/TDO path. After one start request it runs three scans in a row. First it loads the chain-select opcode into the 4-bit instruction register. Then it shifts the requested chain number through the data register. Last it loads the caller's test-mode opcode. It returns the bits that came back on TDO while the chain number was shifted.

TCK is built from the system clock with a programmable clock enable. TMS and TDI are updated only when TCK falls, and TDO is sampled when TCK rises. A model of the full 16-state TAP controller inside the block follows every rising edge, so the block can steer the TAP to the wanted Shift state from wherever it was left. Once the first Update state is reached, every route leads straight to Select-DR-Scan and never through Run-Test/Idle. A core held in debug state therefore stays isolated between the three scans.

The sequencer has five named states:
- Idle: nothing runs and TCK is stopped.
- Navigate: on each falling edge, drive the TMS value that moves toward the segment's Shift state.
- Shift: drive one data bit per falling edge.
- Exit: drive TMS high from Exit1 toward Update.
- Update: either close the request or start the next segment.

Its transitions are:
- Idle to Navigate on an accepted start.
- Navigate to Shift on the falling edge at which the TAP sits in the target Shift state.
- Shift to Exit on the rising edge that moves the last bit.
- Exit to Update on the next falling edge.
- Update to Navigate on a falling edge when a segment remains.
- Update to Idle on a falling edge after the test-mode segment.

Top module: `chain_sel_seq`

## Requirements
- R1: Held in reset, and until the first start, busy, done, tck, tms, tdi and chain_cap are all 0.
- R2: While busy, each TCK high phase and each TCK low phase lasts tck_half+1 system clocks. TCK is low whenever busy is low.
- R3: tms and tdi change only in the system cycle in which TCK falls, or in the cycle in which a start is accepted (TCK is low then).
- R4: One request loads the instruction register with the chain-select opcode (parameter, default 4'b0010), then loads the data register with chain_num, then loads the instruction register with mode_op. At done, the instruction register holds mode_op and the selected chain is chain_num.
- R5: Every scan sends its least significant bit first and sends its last bit with TMS high, so the TAP goes to Exit1 and then to Update.
- R6: After an Update-IR or Update-DR state, the TAP never enters Run-Test/Idle while the block drives it.
- R7: chain_cap returns the 4 TDO bits sampled while chain_num is shifted. The first bit sampled lands in bit 0.
- R8: A start while busy is ignored. chain_num and mode_op are captured when a start is accepted, so later changes have no effect on the running request.
- R9: done is high for exactly one system clock per request. In that cycle busy is already low, and it was high in the cycle before.
- R10: A request works from Test-Logic-Reset, and also from the Update-IR state in which the previous request left the TAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tck_half | input | DIV_W | TCK half period in system clocks, minus one |
| start | input | 1 | Request strobe, taken only while idle |
| chain_num | input | CHAIN_W | Number of the scan chain to select |
| mode_op | input | IR_W | Test-mode opcode loaded after the select |
| tdo | input | 1 | Test data from the TAP |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the TAP |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-clock pulse when a request finishes |
| chain_cap | output | CHAIN_W | TDO bits sampled during the chain-number scan |

## Verification
Some properties are checked on every cycle:
- TCK stays low while idle.
- TMS changes only on a falling TCK or when a start is accepted.
- The tracked TAP state never goes from an Update state to Run-Test/Idle while the block drives it.
- done is a single-clock pulse that closes a busy period.

Other behaviour shows only in the bench's scenarios, using a bench-side TAP with its own instruction and chain-select registers:
- the order and bit order of the three scans;
- the captured TDO bits;
- the exact half-period count;
- that a start issued mid-request does not change the result.

// File: rtl/jsel_pkg.sv
package jsel_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_NAV, PH_SHIFT, PH_EXIT, PH_UPD
    } phase_e;

    localparam logic [1:0] SEG_SEL   = 2'd0;
    localparam logic [1:0] SEG_CHAIN = 2'd1;
    localparam logic [1:0] SEG_MODE  = 2'd2;

    // Standard TAP controller transition on a rising TCK.
    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        unique case (s)
            TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
            TS_IDLE:     n = m ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   n = m ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   n = m ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: n = m ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: n = m ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: n = m ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: n = m ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   n = m ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   n = m ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   n = m ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: n = m ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: n = m ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: n = m ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: n = m ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   n = m ? TS_SEL_DR   : TS_IDLE;
            default:     n = TS_RESET;
        endcase
        return n;
    endfunction

    // TMS that moves one step toward Shift-IR (want_ir) or Shift-DR.
    // Update states always leave through Select-DR-Scan.
    function automatic logic nav_tms(input tap_state_e s, input logic want_ir);
        logic m;
        unique case (s)
            TS_RESET:  m = 1'b0;
            TS_SEL_DR: m = want_ir;
            TS_SEL_IR: m = ~want_ir;
            TS_CAP_DR: m = want_ir;
            TS_CAP_IR: m = ~want_ir;
            default:   m = 1'b1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tck_gen.sv
module tck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] half,
    output logic             tck_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             tck_q;
    logic             wrap;

    assign wrap   = run && (cnt_q == half);
    assign rise_o = wrap && !tck_q;
    assign fall_o = wrap &&  tck_q;
    assign tck_o  = tck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tck_q <= ~tck_q;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tap_tracker.sv
module tap_tracker
    import jsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       tms,
    output tap_state_e state_o
);
    tap_state_e st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= TS_RESET;
        else if (adv) st_q <= tap_next(st_q, tms);
    end

    assign state_o = st_q;
endmodule

// File: rtl/chain_sel_seq.sv
module chain_sel_seq
    import jsel_pkg::*;
#(
    parameter int             IR_W    = 4,
    parameter int             CHAIN_W = 4,
    parameter int             DIV_W   = 8,
    parameter logic [IR_W-1:0] SEL_OP = 4'b0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   tck_half,
    input  logic               start,
    input  logic [CHAIN_W-1:0] chain_num,
    input  logic [IR_W-1:0]    mode_op,
    input  logic               tdo,
    output logic               tck,
    output logic               tms,
    output logic               tdi,
    output logic               busy,
    output logic               done,
    output logic [CHAIN_W-1:0] chain_cap
);
    localparam int SH_W  = (IR_W > CHAIN_W) ? IR_W : CHAIN_W;
    localparam int IDX_W = (SH_W > 1) ? $clog2(SH_W) : 1;
    localparam logic [IDX_W-1:0] IR_LAST    = IDX_W'(IR_W - 1);
    localparam logic [IDX_W-1:0] CHAIN_LAST = IDX_W'(CHAIN_W - 1);

    phase_e             phase_q, phase_d;
    logic [1:0]         seg_q, seg_d;
    logic [IDX_W-1:0]   idx_q, idx_d;
    logic               tms_q, tms_d, tdi_q, tdi_d, done_q, done_d;
    logic [CHAIN_W-1:0] cap_q, cap_d, chain_q;
    logic [IR_W-1:0]    mode_q;
    tap_state_e         tap_q;
    logic               rise_evt, fall_evt, start_acc, act;
    phase_e             eff_phase;
    logic [1:0]         eff_seg;
    logic [IDX_W-1:0]   eff_idx, seg_last;
    logic               seg_ir;
    tap_state_e         target;
    logic [SH_W-1:0]    word;

    assign start_acc = start && (phase_q == PH_IDLE);
    assign act       = start_acc || (fall_evt && (phase_q != PH_IDLE));
    assign eff_phase = start_acc ? PH_NAV  : phase_q;
    assign eff_seg   = start_acc ? SEG_SEL : seg_q;
    assign eff_idx   = start_acc ? '0      : idx_q;
    assign seg_ir    = (eff_seg != SEG_CHAIN);
    assign seg_last  = seg_ir ? IR_LAST : CHAIN_LAST;
    assign target    = seg_ir ? TS_SHIFT_IR : TS_SHIFT_DR;

    tck_gen #(.DIV_W(DIV_W)) u_tck (
        .clk(clk), .rst_n(rst_n), .run(phase_q != PH_IDLE), .restart(start_acc),
        .half(tck_half), .tck_o(tck), .rise_o(rise_evt), .fall_o(fall_evt)
    );

    tap_tracker u_tap (
        .clk(clk), .rst_n(rst_n), .adv(rise_evt), .tms(tms_q), .state_o(tap_q)
    );

    // Word for the active segment, zero-padded to the shift width.
    always_comb begin
        word = '0;
        if (eff_seg == SEG_SEL)        word[IR_W-1:0]    = SEL_OP;
        else if (eff_seg == SEG_CHAIN) word[CHAIN_W-1:0] = chain_q;
        else                           word[IR_W-1:0]    = mode_q;
    end

    // Next-state process: drive decisions on falling TCK, bookkeeping on rising TCK.
    always_comb begin
        phase_d = phase_q;
        seg_d   = seg_q;
        idx_d   = idx_q;
        tms_d   = tms_q;
        tdi_d   = tdi_q;
        cap_d   = cap_q;
        done_d  = 1'b0;
        if (act) begin
            if (start_acc) begin
                seg_d = SEG_SEL;
                idx_d = '0;
                cap_d = '0;
            end
            unique case (eff_phase)
                PH_NAV: begin
                    if (tap_q == target) begin
                        tms_d   = (seg_last == '0);
                        tdi_d   = word[0];
                        phase_d = PH_SHIFT;
                    end else begin
                        tms_d   = nav_tms(tap_q, seg_ir);
                        tdi_d   = 1'b0;
                        phase_d = PH_NAV;
                    end
                end
                PH_SHIFT: begin
                    tms_d = (eff_idx == seg_last);
                    tdi_d = word[eff_idx];
                end
                PH_EXIT: begin
                    tms_d   = 1'b1;
                    tdi_d   = 1'b0;
                    phase_d = PH_UPD;
                end
                PH_UPD: begin
                    if (eff_seg == SEG_MODE) begin
                        phase_d = PH_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        seg_d   = eff_seg + 2'd1;
                        tms_d   = 1'b1;
                        phase_d = PH_NAV;
                    end
                end
                PH_IDLE: ;
            endcase
        end else if (rise_evt && (phase_q == PH_SHIFT)) begin
            if (seg_q == SEG_CHAIN) cap_d = {tdo, cap_q[CHAIN_W-1:1]};
            if (idx_q == seg_last) begin
                idx_d   = '0;
                phase_d = PH_EXIT;
            end else begin
                idx_d = idx_q + 1'b1;
            end
        end
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            seg_q   <= SEG_SEL;
            idx_q   <= '0;
            tms_q   <= 1'b0;
            tdi_q   <= 1'b0;
            cap_q   <= '0;
            done_q  <= 1'b0;
            chain_q <= '0;
            mode_q  <= '0;
        end else begin
            phase_q <= phase_d;
            seg_q   <= seg_d;
            idx_q   <= idx_d;
            tms_q   <= tms_d;
            tdi_q   <= tdi_d;
            cap_q   <= cap_d;
            done_q  <= done_d;
            if (start_acc) begin
                chain_q <= chain_num;
                mode_q  <= mode_op;
            end
        end
    end

    // Output process.
    always_comb begin
        busy      = (phase_q != PH_IDLE);
        done      = done_q;
        tms       = tms_q;
        tdi       = tdi_q;
        chain_cap = cap_q;
    end
endmodule

// File: rtl/jsel_chk.sv
module jsel_chk
    import jsel_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tck,
    input logic       tms,
    input logic       busy,
    input logic       done,
    input tap_state_e tap_st
);
    a_r2_tck_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);

    a_r3_tms_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tms) |-> ($fell(tck) || $rose(busy)));

    a_r6_no_idle_after_update: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (tap_st == TS_UPD_DR || tap_st == TS_UPD_IR)) |=> (tap_st != TS_IDLE));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

bind chain_sel_seq jsel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms),
    .busy(busy), .done(done), .tap_st(tap_q)
);

// File: tb/chain_sel_seq_tb_top.sv
module chain_sel_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tck_half = 8'd0;
    logic       start = 1'b0;
    logic [3:0] chain_num = 4'd0;
    logic [3:0] mode_op = 4'd0;
    logic       tdo = 1'b0;
    logic       tck, tms, tdi, busy, done;
    logic [3:0] chain_cap;

    always #4 clk = ~clk;

    chain_sel_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tck_half(tck_half), .start(start),
        .chain_num(chain_num), .mode_op(mode_op), .tdo(tdo), .tck(tck),
        .tms(tms), .tdi(tdi), .busy(busy), .done(done), .chain_cap(chain_cap)
    );

    int n_chk = 0, n_fail = 0, done_cnt = 0, idle_bad = 0, edge_bad = 0;
    bit reported = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Bench TAP: own 16-state model, 4-bit IR, 4-bit chain-select DR.
    typedef enum logic [3:0] {
        M_TLR, M_RTI, M_SDR, M_CDR, M_SHDR, M_E1DR, M_PDR, M_E2DR, M_UDR,
        M_SIR, M_CIR, M_SHIR, M_E1IR, M_PIR, M_E2IR, M_UIR
    } mst_e;
    mst_e       m_st = M_TLR, m_nx;
    logic [3:0] m_ir_sh = 4'd0, m_ir = 4'd0, m_dr_sh = 4'd0, m_sel = 4'd0, m_cap_pat = 4'd0;

    always_comb begin
        case (m_st)
            M_TLR:  m_nx = tms ? M_TLR  : M_RTI;
            M_RTI:  m_nx = tms ? M_SDR  : M_RTI;
            M_SDR:  m_nx = tms ? M_SIR  : M_CDR;
            M_CDR:  m_nx = tms ? M_E1DR : M_SHDR;
            M_SHDR: m_nx = tms ? M_E1DR : M_SHDR;
            M_E1DR: m_nx = tms ? M_UDR  : M_PDR;
            M_PDR:  m_nx = tms ? M_E2DR : M_PDR;
            M_E2DR: m_nx = tms ? M_UDR  : M_SHDR;
            M_UDR:  m_nx = tms ? M_SDR  : M_RTI;
            M_SIR:  m_nx = tms ? M_TLR  : M_CIR;
            M_CIR:  m_nx = tms ? M_E1IR : M_SHIR;
            M_SHIR: m_nx = tms ? M_E1IR : M_SHIR;
            M_E1IR: m_nx = tms ? M_UIR  : M_PIR;
            M_PIR:  m_nx = tms ? M_E2IR : M_PIR;
            M_E2IR: m_nx = tms ? M_UIR  : M_SHIR;
            default: m_nx = tms ? M_SDR : M_RTI;
        endcase
    end

    always @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= M_TLR;
        end else begin
            if (m_st == M_CIR)  m_ir_sh <= 4'b0001;
            if (m_st == M_SHIR) m_ir_sh <= {tdi, m_ir_sh[3:1]};
            if (m_st == M_CDR)  m_dr_sh <= m_cap_pat;
            if (m_st == M_SHDR) m_dr_sh <= {tdi, m_dr_sh[3:1]};
            if ((m_st == M_UDR || m_st == M_UIR) && m_nx == M_RTI) idle_bad <= idle_bad + 1; // R6
            m_st <= m_nx;
        end
    end

    always @(negedge tck) begin
        tdo <= (m_st == M_SHDR) ? m_dr_sh[0] : (m_st == M_SHIR) ? m_ir_sh[0] : 1'b0;
        if (m_st == M_UIR) m_ir  <= m_ir_sh;
        if (m_st == M_UDR) m_sel <= m_dr_sh;
    end

    // Scoreboard
    typedef struct packed { logic [3:0] chain; logic [3:0] op; logic [3:0] cap; } exp_t;
    exp_t exp_q[$];
    logic p_done = 1'b0, p_tck = 1'b0, p_tms = 1'b0, p_tdi = 1'b0, p_busy = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                done_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 done without accepted request", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(chain_cap == e.cap, "R7 captured chain bits", chain_cap, e.cap);
                    chk(m_sel == e.chain, "R4 R5 selected chain", m_sel, e.chain);
                    chk(m_ir == e.op, "R4 R5 final instruction", m_ir, e.op);
                    chk(!busy, "R9 busy low with done", busy, 0);
                end
                if (p_done) chk(1'b0, "R9 done wider than one clock", 2, 1);
            end
            if (((tms != p_tms) || (tdi != p_tdi)) && !(p_tck && !tck) && !(busy && !p_busy))
                edge_bad++; // R3
            if (!busy && tck) edge_bad++; // R2
        end
        p_done <= done; p_tck <= tck; p_tms <= tms; p_tdi <= tdi; p_busy <= busy;
    end

    // Driver
    task automatic kick(input logic [3:0] ch, input logic [3:0] op, input logic [3:0] cp, input logic [7:0] h);
        @(negedge clk);
        tck_half = h; chain_num = ch; mode_op = op; m_cap_pat = cp;
        exp_q.push_back('{chain: ch, op: op, cap: cp});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_wait();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_measure(input logic [3:0] ch, input logic [3:0] op, input logic [3:0] cp, input logic [7:0] h);
        int n;
        kick(ch, op, cp, h);
        while (!tck) @(negedge clk);
        n = 0;
        while (tck) begin n++; @(negedge clk); end
        chk(n == int'(h) + 1, "R2 tck high phase", n, int'(h) + 1);
        n = 0;
        while (!tck) begin n++; @(negedge clk); end
        chk(n == int'(h) + 1, "R2 tck low phase", n, int'(h) + 1);
        finish_wait();
        chk(!tck, "R2 tck low after done", tck, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        chk({busy, done, tck, tms, tdi} == 5'b0, "R1 control outputs in reset", {busy, done, tck, tms, tdi}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({busy, done, tck, tms, tdi} == 5'b0, "R1 control outputs after reset", {busy, done, tck, tms, tdi}, 0);
        chk(chain_cap == 4'd0, "R1 chain_cap after reset", chain_cap, 0);

        // R10: first request starts from Test-Logic-Reset
        run_measure(4'd2, 4'b1100, 4'hA, 8'd0);
        // R10: later requests start from Update-IR
        run_measure(4'd0, 4'b0101, 4'h3, 8'd2);
        run_measure(4'd15, 4'b1100, 4'h5, 8'd5);
        kick(4'd1, 4'b1111, 4'h8, 8'd1);
        finish_wait();
        kick(4'd9, 4'b0000, 4'h1, 8'd0);
        finish_wait();

        // R8: start while busy ignored, inputs latched at acceptance
        d0 = done_cnt;
        kick(4'd6, 4'b1100, 4'hC, 8'd1);
        repeat (20) @(negedge clk);
        chain_num = 4'd7; mode_op = 4'b0011; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_wait();
        repeat (100) @(negedge clk);
        chk(done_cnt - d0 == 1, "R8 one done per accepted start", done_cnt - d0, 1);
        chk(m_sel == 4'd6, "R8 chain unchanged by ignored start", m_sel, 6);
        chk(!busy, "R8 no second request running", busy, 0);

        chk(idle_bad == 0, "R6 Run-Test/Idle entered from Update", idle_bad, 0);
        chk(edge_bad == 0, "R3 tms/tdi change off falling tck", edge_bad, 0);
        chk(exp_q.size() == 0, "R9 every request completed", exp_q.size(), 0);
        report();
    end
endmodule